// File: doc/BRIEF.md
# Bus-Mapped SPI Master Transceiver

This block lets an 8-bit microprocessor bus drive SPI peripherals. It decodes a chip select, a read strobe, a write strobe and a two-bit address. The CPU writes a byte to the transmit location, and that write starts a transfer with no further command. The block then shifts the byte out MSB first in SPI mode 0 and produces a counted burst of exactly eight serial clock pulses. After the last pulse the serial clock parks low. The byte clocked in on MISO during the burst is copied into a receive register, and the CPU reads it back once the busy flag in the status register has cleared.

A separate select register drives three active-low device-select lines. Two lines are meant for SD cards and one for another device such as a real-time clock. Each device has its own line because the cards cannot share a daisy chain. Software asserts a select before a transfer and releases it afterwards. The serial clock runs at the system clock divided by the even parameter `DIV`.

Top module: `spi_bus_master`

## Requirements
- R1: A bus write is one clock edge with `busSel` and `busWr` high. A write to address 0 while idle loads the byte and sets busy at that edge. From the same edge `mosi` shows bit 7 of the byte and `sclk` stays low.
- R2: Each transfer gives exactly eight `sclk` pulses. Each pulse is high for DIV/2 cycles and low for DIV/2 cycles. `sclk` is low whenever busy is clear.
- R3: Data leaves on `mosi` MSB first. `mosi` changes only on falling `sclk` edges, so it is stable while `sclk` is high.
- R4: `miso` is sampled on each rising `sclk` edge, MSB first. A read of address 2 returns the received byte after the transfer.
- R5: Status is read at address 3, and bit 7 is busy while the other bits read 0. Busy is high at the 8*DIV+1 edges that follow the starting write edge, counting the starting edge itself. Busy clears at the edge 8*DIV+1 cycles after the write. The receive register changes only at that edge.
- R6: A write to address 0 while busy is ignored. The ongoing transfer, the bits sent and the finishing time do not change, and no second transfer follows.
- R7: A write to address 1 drives `devSelN` from data bits 2:0 at the next edge, and a 0 bit asserts its line. This also works during a transfer. Address 1 reads back {5'b0, selects}.
- R8: A synchronous active-high `rst` forces `sclk` low, `mosi` low, `devSelN` to 3'b111, busy to 0 and the receive register to 0. This holds even in the middle of a transfer.
- R9: With `busSel` low, writes have no effect and `busRdData` reads 0. Reads of address 0 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Chip select from the address decoder, active high |
| busRd | input | 1 | Read strobe, active high |
| busWr | input | 1 | Write strobe, sampled at the clock edge |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Write data from the CPU |
| busRdData | output | 8 | Read data to the CPU, combinational |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| devSelN | output | 3 | Active-low device selects |

## Verification
A write edge E0 starts a transfer. Busy and the first `mosi` bit are due at E0. Rising `sclk` edges fall at E0+(2k+1)*DIV/2, and falling edges at E0+(2k+2)*DIV/2. Busy clears and the receive register updates at E0+8*DIV+1. The bench drives bus signals at falling clock edges and samples at the next falling edge, so every register result is read half a cycle after the edge that made it. Its cycle index n counts falling edges after E0, and busy is expected high exactly for n = 0..8*DIV. All 256 transmit bytes are swept, each against a response byte computed from it. The slave model captures `mosi` and supplies `miso` on the serial clock edges.

// File: rtl/spi_bus_pkg.sv
package spi_bus_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // capture write data, start
    logic sample;  // rising sclk edge: latch miso
    logic shift;   // falling sclk edge: advance shift register
    logic finish;  // copy shift register to receive register
  } spiStrobeT;

  typedef enum logic [1:0] {
    ADDR_TX   = 2'd0,
    ADDR_SEL  = 2'd1,
    ADDR_RX   = 2'd2,
    ADDR_STAT = 2'd3
  } regAddrT;
endpackage

// File: rtl/spi_bus_ctrl.sv
module spi_bus_ctrl
  import spi_bus_pkg::*;
#(
  parameter int DIV = 4,
  parameter int DW  = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      startReq,
  output spiStrobeT strobes,
  output logic      busy,
  output logic      sclk
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(DW) + 1;

  logic [PW-1:0] phaseCnt;
  logic [BW-1:0] fallCnt;
  logic          tailPending;
  logic          halfDone;
  logic          running;

  assign halfDone = (phaseCnt == PW'(HALF - 1));
  assign running  = busy && !tailPending;

  always_comb begin
    strobes.load   = startReq && !busy;
    strobes.sample = running && halfDone && !sclk;
    strobes.shift  = running && halfDone && sclk;
    strobes.finish = tailPending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      sclk        <= 1'b0;
      phaseCnt    <= '0;
      fallCnt     <= '0;
      tailPending <= 1'b0;
    end else if (strobes.load) begin
      busy        <= 1'b1;
      sclk        <= 1'b0;
      phaseCnt    <= '0;
      fallCnt     <= '0;
      tailPending <= 1'b0;
    end else if (tailPending) begin
      busy        <= 1'b0;
      tailPending <= 1'b0;
    end else if (busy) begin
      if (halfDone) begin
        phaseCnt <= '0;
        sclk     <= ~sclk;
        if (sclk) begin
          fallCnt <= fallCnt + 1'b1;
          if (fallCnt == BW'(DW - 1)) tailPending <= 1'b1;
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_bus_datapath.sv
module spi_bus_datapath
  import spi_bus_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NSEL = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  spiStrobeT       strobes,
  input  logic            busy,
  input  logic            busSel,
  input  logic            busRd,
  input  logic            busWr,
  input  logic [1:0]      busAddr,
  input  logic [DW-1:0]   busWrData,
  output logic [DW-1:0]   busRdData,
  input  logic            miso,
  output logic            mosi,
  output logic [NSEL-1:0] devSelN,
  output logic [DW-1:0]   rxByte
);
  logic [DW-1:0]   shiftReg;
  logic [NSEL-1:0] selReg;
  logic            misoBit;
  logic            selWrite;

  assign selWrite = busSel && busWr && (regAddrT'(busAddr) == ADDR_SEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      rxByte   <= '0;
      selReg   <= '1;
      misoBit  <= 1'b0;
    end else begin
      if (strobes.load)       shiftReg <= busWrData;
      else if (strobes.shift) shiftReg <= {shiftReg[DW-2:0], misoBit};
      if (strobes.sample) misoBit <= miso;
      if (strobes.finish) rxByte  <= shiftReg;
      if (selWrite)       selReg  <= busWrData[NSEL-1:0];
    end
  end

  assign mosi    = busy & shiftReg[DW-1];
  assign devSelN = selReg;

  always_comb begin
    busRdData = '0;
    if (busSel && busRd) begin
      unique case (regAddrT'(busAddr))
        ADDR_TX:   busRdData = '0;
        ADDR_SEL:  busRdData = DW'(selReg);
        ADDR_RX:   busRdData = rxByte;
        ADDR_STAT: busRdData = {busy, {(DW-1){1'b0}}};
        default:   busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_bus_master.sv
module spi_bus_master
  import spi_bus_pkg::*;
#(
  parameter int DIV  = 4,
  parameter int DW   = 8,
  parameter int NSEL = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busSel,
  input  logic            busRd,
  input  logic            busWr,
  input  logic [1:0]      busAddr,
  input  logic [DW-1:0]   busWrData,
  output logic [DW-1:0]   busRdData,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NSEL-1:0] devSelN
);
  spiStrobeT     strobes;
  logic          busyFlag;
  logic [DW-1:0] rxByte;
  logic          txWrite;

  assign txWrite = busSel && busWr && (regAddrT'(busAddr) == ADDR_TX);

  spi_bus_ctrl #(.DIV(DIV), .DW(DW)) ctrl (
    .clk(clk), .rst(rst), .startReq(txWrite),
    .strobes(strobes), .busy(busyFlag), .sclk(sclk)
  );

  spi_bus_datapath #(.DW(DW), .NSEL(NSEL)) dp (
    .clk(clk), .rst(rst), .strobes(strobes), .busy(busyFlag),
    .busSel(busSel), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .miso(miso), .mosi(mosi), .devSelN(devSelN), .rxByte(rxByte)
  );
endmodule

// File: rtl/spi_bus_master_chk.sv
module spi_bus_master_chk #(
  parameter int DW   = 8,
  parameter int NSEL = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            busSel,
  input logic            busWr,
  input logic [1:0]      busAddr,
  input logic [DW-1:0]   busWrData,
  input logic            sclk,
  input logic            mosi,
  input logic [NSEL-1:0] devSelN,
  input logic            busyFlag,
  input logic [DW-1:0]   rxByte
);
  logic txWr, selWr;
  assign txWr  = busSel && busWr && (busAddr == 2'd0);
  assign selWr = busSel && busWr && (busAddr == 2'd1);

  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    (txWr && !busyFlag) |=> (busyFlag && !sclk && (mosi == $past(busWrData[DW-1]))));

  assert_sclk_parks_R2: assert property (@(posedge clk) disable iff (rst)
    !busyFlag |-> !sclk);

  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (rst)
    sclk |=> (!sclk || $stable(mosi)));

  assert_rx_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    busyFlag |=> ($stable(rxByte) || !busyFlag));

  assert_sel_follows_R7: assert property (@(posedge clk) disable iff (rst)
    selWr |=> (devSelN == $past(busWrData[NSEL-1:0])));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!sclk && !mosi && (devSelN == '1) && !busyFlag && (rxByte == '0)));
endmodule

bind spi_bus_master spi_bus_master_chk #(.DW(DW), .NSEL(NSEL)) chk (
  .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWrData(busWrData), .sclk(sclk), .mosi(mosi), .devSelN(devSelN),
  .busyFlag(busyFlag), .rxByte(rxByte)
);

// File: tb/tb_spi_bus_master.sv
module tb_spi_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int BUSY_CYC = 8 * DIV + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busSel = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       sclk, mosi, miso;
  logic [2:0] devSelN;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  logic [7:0] slaveOut = 8'd0;
  logic [7:0] slaveIn  = 8'd0;
  int         riseCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bus_master #(.DIV(DIV)) dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .devSelN(devSelN)
  );

  // mode-0 slave model
  assign miso = slaveOut[7];
  always @(posedge sclk) begin
    slaveIn   = {slaveIn[6:0], mosi};
    riseCount = riseCount + 1;
  end
  always @(negedge sclk) slaveOut = {slaveOut[6:0], 1'b0};

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    busSel = 1'b1; busRd = 1'b1; busWr = 1'b0; busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    busSel = sel; busWr = 1'b1; busRd = 1'b0; busAddr = a; busWrData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // one transfer; midAt >= 0 injects a TX write then a select write
  task automatic transfer(input logic [7:0] tx, input logic [7:0] resp,
                          input int midAt, input logic [7:0] midTx, input logic [2:0] midSel);
    logic [7:0] v;
    int highCnt = 0;
    logic prevSclk = 1'b0;
    logic prevMosi = 1'b0;
    slaveOut = resp; slaveIn = 8'd0; riseCount = 0;
    writeReg(2'd0, tx, 1'b1);
    // now at negedge n = 0 after the write edge
    check(mosi == tx[7] && sclk == 1'b0, "R1 first bit", {sclk, mosi}, {1'b0, tx[7]});
    for (int n = 0; n <= BUSY_CYC + 1; n++) begin
      if (n > 0) @(negedge clk);
      if (midAt >= 0 && n == midAt) begin
        busSel = 1'b1; busRd = 1'b0; busWr = 1'b1; busAddr = 2'd0; busWrData = midTx;
      end else if (midAt >= 0 && n == midAt + 1) begin
        busAddr = 2'd1; busWrData = {5'd0, midSel};
      end else if (midAt >= 0 && n == midAt + 2) begin
        busWr = 1'b0; busSel = 1'b0;
        check(devSelN == midSel, "R7 select during transfer", devSelN, midSel);
      end else begin
        busWr = 1'b0;
        readReg(2'd3, v);
        check(v == ((n < BUSY_CYC) ? 8'h80 : 8'h00), "R5 busy timing", v,
              (n < BUSY_CYC) ? 8'h80 : 8'h00);
      end
      if (sclk) highCnt++;
      if (sclk && prevSclk)
        check(mosi == prevMosi, "R3 mosi steady while sclk high", mosi, prevMosi);
      prevSclk = sclk; prevMosi = mosi;
    end
    busSel = 1'b0; busRd = 1'b0; busWr = 1'b0;
    check(sclk == 1'b0, "R2 sclk parked", sclk, 0);
    check(riseCount == 8, "R2 pulse count", riseCount, 8);
    check(highCnt == 8 * HALF, "R2 high time", highCnt, 8 * HALF);
    check(slaveIn == tx, "R3 mosi byte MSB first", slaveIn, tx);
    @(negedge clk);
    readReg(2'd2, v);
    check(v == resp, "R4 received byte", v, resp);
    busSel = 1'b0; busRd = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    check(sclk == 1'b0 && mosi == 1'b0, "R8 reset lines", {sclk, mosi}, 0);
    check(devSelN == 3'b111, "R8 reset selects", devSelN, 3'b111);
    rst = 1'b0;
    @(negedge clk);
    readReg(2'd3, v); check(v == 8'h00, "R8 reset busy", v, 0);
    readReg(2'd2, v); check(v == 8'h00, "R8 reset rx", v, 0);
    readReg(2'd0, v); check(v == 8'h00, "R9 tx reads zero", v, 0);
    busSel = 1'b0; busRd = 1'b1; busAddr = 2'd1;
    #1 check(busRdData == 8'h00, "R9 unselected read", busRdData, 0);
    busRd = 1'b0;

    // R7: every select pattern, with readback
    for (int s = 0; s < 8; s++) begin
      writeReg(2'd1, 8'(s), 1'b1);
      check(devSelN == 3'(s), "R7 select drive", devSelN, s);
      readReg(2'd1, v); check(v == 8'(s), "R7 select readback", v, s);
      busSel = 1'b0; busRd = 1'b0;
    end
    // R9: writes without chip select
    writeReg(2'd1, 8'h05, 1'b0);
    check(devSelN == 3'b111, "R9 select write ignored", devSelN, 3'b111);
    writeReg(2'd0, 8'hFF, 1'b0);
    check(sclk == 1'b0 && mosi == 1'b0, "R9 tx write ignored", {sclk, mosi}, 0);
    readReg(2'd3, v); check(v == 8'h00, "R9 no busy", v, 0);
    busSel = 1'b0; busRd = 1'b0;

    // R1..R5 sweep over all transmit bytes
    for (int t = 0; t < 256; t++)
      transfer(8'(t), 8'((t * 37 + 11) % 256), -1, 8'd0, 3'd0);

    // R6: TX write while busy ignored; R7 select write during transfer
    transfer(8'hA5, 8'h3C, 9, 8'h5A, 3'b010);
    @(negedge clk);
    readReg(2'd3, v); check(v == 8'h00, "R6 no second transfer", v, 0);
    busSel = 1'b0; busRd = 1'b0;
    check(riseCount == 8, "R6 no extra pulses", riseCount, 8);

    // R8: reset in mid transfer
    slaveOut = 8'hFF;
    writeReg(2'd0, 8'hFF, 1'b1);
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(sclk == 1'b0 && mosi == 1'b0, "R8 mid-transfer reset lines", {sclk, mosi}, 0);
    check(devSelN == 3'b111, "R8 mid-transfer reset selects", devSelN, 3'b111);
    readReg(2'd3, v); check(v == 8'h00, "R8 mid-transfer reset busy", v, 0);
    readReg(2'd2, v); check(v == 8'h00, "R8 mid-transfer reset rx", v, 0);
    busSel = 1'b0; busRd = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      vectors++; misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule